// File: doc/BRIEF.md
# Hadamard Spectral Test Pattern Generator

This block rebuilds a test sequence for a circuit under test from a small set of Walsh-Hadamard spectral coefficients. Each of its output streams has its own list of retained coefficients. Each list entry holds a signed weight and the basis column that the weight belongs to. Coefficients that were not kept count as zero.

For time index t, every stream forms the sum of weight × H(t, column) over its list. The Hadamard entry is computed on the fly in Sylvester ordering: it is +1 when the number of set bits in (t AND column) is even, and −1 when that number is odd. The stream's output bit is the sign of the sum. The sequence has 2^K patterns. A run either stops after the last pattern or starts over at t = 0.

The list is accumulated serially, one entry per clock. Each pattern therefore takes NC cycles, and all streams are worked out in parallel.

Top module: `hadamard_tpg`

## Requirements
- R1: With `ld_en` high while the block is idle (`busy` low), the entry (`ld_index`, `ld_value`) is written into slot `ld_slot` of stream `ld_stream`. All other entries keep their contents.
- R2: The Hadamard sign for time t and column c is +1 when popcount(t & c) is even and −1 when it is odd. Stream s uses the sum S = Σ over its NC slots of value × sign(t, index).
- R3: Bit s of `pat_out` is 1 when S > 0 and 0 when S ≤ 0. A sum of exactly zero gives 0.
- R4: `start` sampled high while idle begins a run. `pat_valid` is then high for one cycle per pattern. The first pulse comes NC cycles after the clock edge that accepted `start`, and each further pulse comes NC cycles after the one before it. `pat_valid` is never high outside a run.
- R5: The patterns of a run appear in the order t = 0, 1, …, 2^K − 1.
- R6: When `repeat_mode` is low at the edge that produces pattern 2^K − 1, `done` is high in the same cycle as that pattern's `pat_valid`. `busy` is low from the next cycle on.
- R7: When `repeat_mode` is high at that edge, `done` stays low and the next pattern is t = 0, produced NC cycles later.
- R8: An `ld_en` while `busy` is high is ignored. Later runs produce the patterns of the coefficients held before the attempt.
- R9: A `start` while `busy` is high is ignored. The time order and the timing of the run are not disturbed.
- R10: After reset, all coefficients are zero, and `pat_out`, `pat_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Coefficient write strobe |
| ld_stream | input | clog2(NS) | Stream selected for the write |
| ld_slot | input | clog2(NC) | List slot selected for the write |
| ld_index | input | K | Hadamard column of the coefficient |
| ld_value | input | CW | Signed coefficient weight |
| start | input | 1 | Begin a run when idle |
| repeat_mode | input | 1 | Wrap to t = 0 instead of stopping |
| pat_out | output | NS | One generated bit per stream |
| pat_valid | output | 1 | `pat_out` holds a new pattern |
| done | output | 1 | Last pattern of a non-repeating run |
| busy | output | 1 | A run is in progress |

## Verification
The collision under test puts a coefficient write and a second `start` into the same cycle as a `pat_valid` pulse in the middle of a run. The bench drives both strobes on the negative edge of the clock while it is taking in a pattern. The remaining patterns of that run must keep their order and their NC-cycle spacing. A later run must still match the coefficients held before the attempt. A second collision puts the drop of `repeat_mode` into the middle of a wrapped lap. `done` must then appear only with the t = 2^K − 1 pattern of that lap, and not at the wrap that came before it.

// File: rtl/hadamard_tpg.sv
module hadamard_tpg #(
  parameter int K  = 6,
  parameter int NS = 4,
  parameter int NC = 8,
  parameter int CW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [(NS>1?$clog2(NS):1)-1:0] ld_stream,
  input  logic [(NC>1?$clog2(NC):1)-1:0] ld_slot,
  input  logic [K-1:0]                  ld_index,
  input  logic signed [CW-1:0]          ld_value,
  input  logic                          start,
  input  logic                          repeat_mode,
  output logic [NS-1:0]                 pat_out,
  output logic                          pat_valid,
  output logic                          done,
  output logic                          busy
);
  localparam int SW = NC > 1 ? $clog2(NC) : 1;
  localparam int AW = CW + SW + 1;
  localparam logic [K-1:0] TMAX = {K{1'b1}};

  logic signed [CW-1:0] cval [NS][NC];
  logic [K-1:0]         cidx [NS][NC];
  logic [SW-1:0]        slot;
  logic [K-1:0]         t;
  logic                 last_slot;

  assign last_slot = (slot == SW'(NC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int j = 0; j < NC; j++) begin
          cval[s][j] <= '0;
          cidx[s][j] <= '0;
        end
    end else if (ld_en && !busy && int'(ld_stream) < NS && int'(ld_slot) < NC) begin
      cval[ld_stream][ld_slot] <= ld_value;
      cidx[ld_stream][ld_slot] <= ld_index;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      slot      <= '0;
      t         <= '0;
      pat_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      pat_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          slot <= '0;
          t    <= '0;
        end
      end else if (last_slot) begin
        slot      <= '0;
        pat_valid <= 1'b1;
        if (t == TMAX) begin
          t <= '0;
          if (!repeat_mode) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          t <= t + 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_stream
    logic signed [AW-1:0] acc, mag, term, sum;
    logic                 flip;

    assign mag  = AW'(cval[s][slot]);
    assign flip = ^(t & cidx[s][slot]);
    assign term = flip ? -mag : mag;
    assign sum  = acc + term;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc        <= '0;
        pat_out[s] <= 1'b0;
      end else if (busy) begin
        if (last_slot) begin
          acc        <= '0;
          pat_out[s] <= (sum > 0);
        end else begin
          acc <= sum;
        end
      end
    end

    p_store_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cval[s][0]) && $stable(cidx[s][0])));
  end

  p_done_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pat_valid);
  p_done_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_no_done_in_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(repeat_mode));
  p_valid_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> $past(busy));
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && NC > 1) |=> !pat_valid);
endmodule

// File: tb/hadamard_tpg_tb.sv
`timescale 1ns/1ps
module hadamard_tpg_tb;
  localparam int K = 6, NS = 4, NC = 8, CW = 8;
  localparam int TLEN = 1 << K;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0, start = 0, repeat_mode = 0;
  logic [1:0] ld_stream = 0;
  logic [2:0] ld_slot = 0;
  logic [K-1:0] ld_index = 0;
  logic signed [CW-1:0] ld_value = 0;
  logic [NS-1:0] pat_out;
  logic pat_valid, done, busy;

  int n_cmp = 0, n_bad = 0;
  int m_val [NS][NC];
  int m_idx [NS][NC];

  always #2.5 clk = ~clk;

  hadamard_tpg #(.K(K), .NS(NS), .NC(NC), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_stream(ld_stream),
    .ld_slot(ld_slot), .ld_index(ld_index), .ld_value(ld_value),
    .start(start), .repeat_mode(repeat_mode), .pat_out(pat_out),
    .pat_valid(pat_valid), .done(done), .busy(busy));

  function automatic logic [NS-1:0] exp_vec(int tt);
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) begin
      int sum = 0;
      for (int j = 0; j < NC; j++)
        sum += ($countones(tt & m_idx[s][j]) % 2) ? -m_val[s][j] : m_val[s][j];
      v[s] = (sum > 0);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load(input int s, input int j, input int idx, input int val, input bit accepted);
    @(negedge clk);
    ld_en = 1; ld_stream = 2'(s); ld_slot = 3'(j); ld_index = K'(idx); ld_value = CW'(val);
    @(negedge clk);
    ld_en = 0;
    if (accepted) begin m_val[s][j] = val; m_idx[s][j] = idx; end
  endtask

  task automatic rand_load(input int zero_pct);
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < NC; j++) begin
        int v = int'($urandom_range(255)) - 128;
        if (int'($urandom_range(99)) < zero_pct) v = 0;
        load(s, j, int'($urandom_range(TLEN - 1)), v, 1);
      end
  endtask

  // npat patterns; repeat_mode dropped at drop_at; start+load collision at poke_at
  task automatic run(input int npat, input bit rep, input int drop_at, input int poke_at, input string req);
    @(negedge clk);
    repeat_mode = rep; start = 1;
    for (int i = 0; i < npat; i++) begin
      int cnt = 0;
      do begin
        @(negedge clk);
        start = 0; ld_en = 0;
        cnt++;
      end while (!pat_valid && cnt <= 4 * NC);
      check(cnt == (i == 0 ? NC + 1 : NC), "R4 spacing", cnt, i == 0 ? NC + 1 : NC);
      check(pat_out == exp_vec(i % TLEN), {req, " R2/R3/R5 pattern"}, int'(pat_out), int'(exp_vec(i % TLEN)));
      check(done == (i == npat - 1 && !rep_at(rep, drop_at, i)), "R6/R7 done",
            int'(done), int'(i == npat - 1 && !rep_at(rep, drop_at, i)));
      if (i == drop_at) repeat_mode = 0;
      if (i == poke_at) begin
        start = 1; ld_en = 1; ld_stream = 0; ld_slot = 0; ld_index = 0; ld_value = 8'sd127;
      end
    end
    @(negedge clk);
    start = 0; ld_en = 0;
    check(busy == 0 && pat_valid == 0, "R6 idle after done", int'(busy), 0);
  endtask

  function automatic bit rep_at(input bit rep, input int drop_at, input int i);
    return rep && (drop_at < 0 || i <= drop_at);
  endfunction

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'd7321));
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < NC; j++) begin m_val[s][j] = 0; m_idx[s][j] = 0; end
    #1;
    check(pat_out == 0 && pat_valid == 0 && done == 0 && busy == 0, "R10 reset outputs", int'(pat_out), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(TLEN, 0, -1, -1, "R10 zero coefficients");
    // directed: cancelling pair gives zero sum -> 0 (R3); single column parity (R2)
    load(0, 0, 5, 40, 1);
    load(0, 1, 5, -40, 1);
    load(1, 0, 3, 1, 1);
    load(2, 0, 0, -128, 1);
    load(3, 0, 63, 127, 1);
    load(3, 1, 1, 126, 1);
    run(TLEN, 0, -1, -1, "R1 directed");
    for (int r = 0; r < 3; r++) begin
      rand_load(r * 30);
      run(TLEN, 0, -1, -1, "R1 random");
    end
    // R8 R9: load and start collide with a pattern in mid-run
    rand_load(20);
    run(TLEN, 0, -1, 17, "R9 start ignored");
    run(TLEN, 0, -1, -1, "R8 load ignored");
    // R7: wrap twice, drop repeat in third lap
    run(3 * TLEN, 1, 2 * TLEN + 10, -1, "R7 repeat");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule